// File: doc/BRIEF.md
# Serial Port Interrupt Request Logic

This block turns the status events of a serial communication port into five interrupt request lines: normal receive data, receive data with error, transmit data empty, idle line and baud timer underflow. A 16-bit control word written through a simple write strobe holds one enable bit per source. Each request line is the logical AND of its enable bit and a condition. Depending on the source, the condition is a level from the data path or a sticky flag held inside the block.

Each source has its own clearing rule. The data-full flag is cleared by a read of the receive data register. The receive error flag is cleared only by a status register read. The idle and timer flags are cleared by their interrupt acknowledge strobes. An idle-line detector counts consecutive high samples of the receive line, one sample per bit-time strobe. It fires after 10 samples, or after 11 when the long frame format is selected. Once it has fired, it stays quiet until a low sample has been seen. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `sio_irq_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, all five request lines are low, all enables are zero and all flags are clear.
- R2: A control write takes its enables from data bits 10 (idle), 11 (both receive requests), 12 (transmit) and 13 (timer). All other data bits have no effect. The new enables act from the cycle after the write.
- R3: A `rx_load` with no error bit set marks the data register full. `irq_rx` is high while the receive enable is set, the register is full and no error flag is held. `rx_data_rd` clears the full mark, and a load in the same cycle as a read leaves it set.
- R4: A `rx_load` with any of the parity, framing or overrun bits set sets the error flag, and `irq_rx_err` is high while the receive enable and that flag are both set. Only `stat_rd` clears the flag, `rx_data_rd` leaves it alone, and an erroneous load in the same cycle as `stat_rd` keeps it set.
- R5: `irq_rx` and `irq_rx_err` are never high together. A held error flag suppresses `irq_rx` until the status read.
- R6: `irq_tx` follows `tx_empty` gated by the transmit enable, with no added delay.
- R7: A `tmr_uflow` pulse latches the timer flag, and `irq_tmr` is the flag gated by the timer enable. `ack_tmr` clears the flag, but an underflow in the same cycle as the acknowledge keeps it set.
- R8: With `long_frame` low, the 10th consecutive high sample on a `bit_tick` sets the idle flag, visible the cycle after that tick. With `long_frame` high, the 11th consecutive high sample does so.
- R9: A low sample restarts the count. After the flag has been set, further high samples do not set it again until a low sample has re-armed the detector.
- R10: `ack_idle` clears the idle flag, and a detection in the same cycle as the acknowledge keeps it set.
- R11: The error, timer and idle flags latch even while their enable is off. Setting the enable later raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| stat_rd | input | 1 | Status register read strobe |
| rx_load | input | 1 | Word transferred into receive data register |
| rx_par_err | input | 1 | Parity error qualifier for `rx_load` |
| rx_frm_err | input | 1 | Framing error qualifier for `rx_load` |
| rx_ovr_err | input | 1 | Overrun error qualifier for `rx_load` |
| rx_data_rd | input | 1 | Receive data register read strobe |
| tx_empty | input | 1 | Transmit data register empty level |
| tmr_uflow | input | 1 | Baud counter underflow pulse |
| rx_line | input | 1 | Receive line level |
| bit_tick | input | 1 | One pulse per bit time, samples `rx_line` |
| long_frame | input | 1 | Selects the 11-sample idle threshold |
| ack_idle | input | 1 | Idle interrupt acknowledge |
| ack_tmr | input | 1 | Timer interrupt acknowledge |
| irq_rx | output | 1 | Normal receive request |
| irq_rx_err | output | 1 | Receive-with-error request |
| irq_tx | output | 1 | Transmit empty request |
| irq_idle | output | 1 | Idle line request |
| irq_tmr | output | 1 | Timer request |

## Verification
The colliding pairs are a flag being set and that same flag being cleared in one cycle. This happens for a load against a data read, an erroneous load against a status read, an underflow against a timer acknowledge, and a completed idle count against an idle acknowledge. The bench drives both strobes together in one clock and then reads the request line after that edge. The set must have won, and a following clear-only cycle must drop the line, which shows the flag was really held.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned EN_LSB   = 10;
  localparam int unsigned EN_W     = 4;
  localparam int unsigned IDLE_SHORT = 10;
  localparam int unsigned IDLE_LONG  = 11;

  typedef struct packed {
    logic tmr;
    logic tx;
    logic rx;
    logic idle;
  } irq_en_t;
endpackage

// File: rtl/sio_irq_rst_sync.sv
module sio_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/sio_irq_ctrl_reg.sv
module sio_irq_ctrl_reg
  import sio_irq_pkg::*;
#(
  parameter int unsigned DW  = CTRL_W,
  parameter int unsigned LSB = EN_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output irq_en_t       en
);
  localparam int unsigned MSB = LSB + EN_W - 1;

  irq_en_t en_q;
  irq_en_t en_d;
  logic    en_ce;

  always_comb begin
    en_ce = wr;
    en_d  = irq_en_t'(wdata[MSB:LSB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/sio_irq_rx_flags.sv
module sio_irq_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic err_any,
  input  logic data_rd,
  input  logic stat_rd,
  output logic full,
  output logic err
);
  logic full_q, full_d, full_ce;
  logic err_q, err_d, err_ce;

  always_comb begin
    full_ce = load | data_rd;
    full_d  = load;
    err_ce  = (load & err_any) | stat_rd;
    err_d   = load & err_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (full_ce) full_q <= full_d;
      if (err_ce)  err_q  <= err_d;
    end
  end

  assign full = full_q;
  assign err  = err_q;
endmodule

// File: rtl/sio_irq_latch.sv
module sio_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_q, q_d, q_ce;

  always_comb begin
    q_ce = set | clr;
    q_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_ce) q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/sio_irq_idle_det.sv
module sio_irq_idle_det #(
  parameter int unsigned SHORT_N = 10,
  parameter int unsigned LONG_N  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic long_sel,
  output logic fire
);
  localparam int unsigned MAX_N = (LONG_N > SHORT_N) ? LONG_N : SHORT_N;
  localparam int unsigned CW    = $clog2(MAX_N + 1);
  localparam logic [CW-1:0] THR_S = CW'(SHORT_N);
  localparam logic [CW-1:0] THR_L = CW'(LONG_N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          arm_q, arm_d;
  logic          ce;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_inc;

  always_comb begin
    thr     = long_sel ? THR_L : THR_S;
    cnt_inc = cnt_q + 1'b1;
    ce      = tick;
    cnt_d   = cnt_q;
    arm_d   = arm_q;
    fire    = 1'b0;
    if (tick) begin
      if (line) begin
        if (cnt_q < thr) cnt_d = cnt_inc;
        if (arm_q && (cnt_inc == thr)) begin
          fire  = 1'b1;
          arm_d = 1'b0;
        end
      end else begin
        cnt_d = '0;
        arm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b1;
    end else if (ce) begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int unsigned DW       = CTRL_W,
  parameter int unsigned IDLE_S   = IDLE_SHORT,
  parameter int unsigned IDLE_L   = IDLE_LONG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] ctrl_wdata,
  input  logic          stat_rd,
  input  logic          rx_load,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          rx_ovr_err,
  input  logic          rx_data_rd,
  input  logic          tx_empty,
  input  logic          tmr_uflow,
  input  logic          rx_line,
  input  logic          bit_tick,
  input  logic          long_frame,
  input  logic          ack_idle,
  input  logic          ack_tmr,
  output logic          irq_rx,
  output logic          irq_rx_err,
  output logic          irq_tx,
  output logic          irq_idle,
  output logic          irq_tmr
);
  localparam int unsigned NLATCH = 2;
  localparam int unsigned L_IDLE = 0;
  localparam int unsigned L_TMR  = 1;

  logic    rst_n_s;
  irq_en_t en;
  logic    rx_full, rx_err, err_any;
  logic    idle_fire;
  logic [NLATCH-1:0] l_set, l_clr, l_q;

  sio_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  sio_irq_ctrl_reg #(.DW(DW), .LSB(EN_LSB)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .wr(ctrl_wr), .wdata(ctrl_wdata), .en(en)
  );

  assign err_any = rx_par_err | rx_frm_err | rx_ovr_err;

  sio_irq_rx_flags u_rx (
    .clk(clk), .rst_n(rst_n_s), .load(rx_load), .err_any(err_any),
    .data_rd(rx_data_rd), .stat_rd(stat_rd), .full(rx_full), .err(rx_err)
  );

  sio_irq_idle_det #(.SHORT_N(IDLE_S), .LONG_N(IDLE_L)) u_idle (
    .clk(clk), .rst_n(rst_n_s), .tick(bit_tick), .line(rx_line),
    .long_sel(long_frame), .fire(idle_fire)
  );

  assign l_set[L_IDLE] = idle_fire;
  assign l_clr[L_IDLE] = ack_idle;
  assign l_set[L_TMR]  = tmr_uflow;
  assign l_clr[L_TMR]  = ack_tmr;

  for (genvar g = 0; g < NLATCH; g++) begin : g_ack_latch
    sio_irq_latch u_lat (
      .clk(clk), .rst_n(rst_n_s), .set(l_set[g]), .clr(l_clr[g]), .q(l_q[g])
    );
  end

  always_comb begin
    irq_rx_err = en.rx & rx_err;
    irq_rx     = en.rx & rx_full & ~rx_err;
    irq_tx     = en.tx & tx_empty;
    irq_idle   = en.idle & l_q[L_IDLE];
    irq_tmr    = en.tmr & l_q[L_TMR];
  end
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_wr,
  input logic stat_rd,
  input logic rx_load,
  input logic rx_data_rd,
  input logic tx_empty,
  input logic tmr_uflow,
  input logic rx_line,
  input logic bit_tick,
  input logic ack_idle,
  input logic ack_tmr,
  input logic irq_rx,
  input logic irq_rx_err,
  input logic irq_tx,
  input logic irq_idle,
  input logic irq_tmr
);
  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_rx_err)); // R5
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_err && !stat_rd && !ctrl_wr) |=> irq_rx_err); // R4
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_rd && !rx_load) |=> !irq_rx); // R3
  AST_TX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |-> !irq_tx); // R6
  AST_TMR_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr && !tmr_uflow) |=> !irq_tmr); // R7
  AST_IDLE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_idle && !bit_tick) |=> !irq_idle); // R10
  AST_IDLE_LOW_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_line && !irq_idle && !ctrl_wr) |=> !irq_idle); // R9
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
  .rx_load(rx_load), .rx_data_rd(rx_data_rd), .tx_empty(tx_empty),
  .tmr_uflow(tmr_uflow), .rx_line(rx_line), .bit_tick(bit_tick),
  .ack_idle(ack_idle), .ack_tmr(ack_tmr), .irq_rx(irq_rx),
  .irq_rx_err(irq_rx_err), .irq_tx(irq_tx), .irq_idle(irq_idle),
  .irq_tmr(irq_tmr)
);

// File: tb/sio_irq_ctrl_test.sv
module sio_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic ctrl_wr;
  logic [15:0] ctrl_wdata;
  logic stat_rd, rx_load, rx_par_err, rx_frm_err, rx_ovr_err, rx_data_rd;
  logic tx_empty, tmr_uflow, rx_line, bit_tick, long_frame, ack_idle, ack_tmr;
  logic irq_rx, irq_rx_err, irq_tx, irq_idle, irq_tmr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .rx_load(rx_load), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_ovr_err(rx_ovr_err), .rx_data_rd(rx_data_rd),
    .tx_empty(tx_empty), .tmr_uflow(tmr_uflow), .rx_line(rx_line),
    .bit_tick(bit_tick), .long_frame(long_frame), .ack_idle(ack_idle),
    .ack_tmr(ack_tmr), .irq_rx(irq_rx), .irq_rx_err(irq_rx_err),
    .irq_tx(irq_tx), .irq_idle(irq_idle), .irq_tmr(irq_tmr)
  );

  // Vector: [18] write, [17:14] enables {tmr,tx,rx,idle}, [13] load,
  // [12] parity, [11] framing, [10] overrun, [9] data read, [8] status read,
  // [7] tx_empty, [6] underflow, [5] timer ack,
  // [4:0] expected {irq_rx, irq_rx_err, irq_tx, irq_idle, irq_tmr}
  localparam int NV = 19;
  localparam logic [18:0] VEC [NV] = '{
    19'b1_0000_0000_00_0_00_00000, // R2 all enables off
    19'b0_0000_1000_00_0_00_00000, // R3 load while disabled
    19'b1_0010_0000_00_0_00_10000, // R2 R3 enable rx shows request
    19'b0_0000_0000_00_0_00_10000, // R3 level held
    19'b0_0000_0000_10_0_00_00000, // R3 data read clears
    19'b0_0000_1100_00_0_00_01000, // R4 R5 parity error load
    19'b0_0000_0000_10_0_00_01000, // R4 data read leaves error
    19'b0_0000_0000_01_0_00_00000, // R4 status read clears
    19'b0_0000_1001_01_0_00_01000, // R4 overrun load beats status read
    19'b0_0000_0000_01_0_00_10000, // R5 error gone, normal rx returns
    19'b0_0000_1010_10_0_00_01000, // R3 R4 framing load beats data read
    19'b0_0000_0000_11_0_00_00000, // R4 both reads clear
    19'b1_0100_0000_00_1_00_00100, // R6 tx enabled and empty
    19'b0_0000_0000_00_0_00_00000, // R6 tx not empty
    19'b0_0000_0000_00_0_10_00000, // R11 underflow while disabled
    19'b1_1000_0000_00_0_00_00001, // R11 enable timer shows latched flag
    19'b0_0000_0000_00_0_01_00000, // R7 ack clears
    19'b0_0000_0000_00_0_11_00001, // R7 underflow beats ack
    19'b0_0000_0000_00_0_01_00000  // R7 ack clears again
  };

  task automatic idle_all();
    ctrl_wr = 0; ctrl_wdata = '0; stat_rd = 0; rx_load = 0; rx_par_err = 0;
    rx_frm_err = 0; rx_ovr_err = 0; rx_data_rd = 0; tmr_uflow = 0;
    bit_tick = 0; ack_idle = 0; ack_tmr = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq {rx,err,tx,idle,tmr} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {irq_rx, irq_rx_err, irq_tx, irq_idle, irq_tmr};
  endfunction

  task automatic write_en(input logic [3:0] e);
    ctrl_wr = 1; ctrl_wdata = 16'(e) << 10; step(); idle_all();
  endtask

  task automatic tick(input logic lvl, input logic ack);
    bit_tick = 1; rx_line = lvl; ack_idle = ack; step(); idle_all();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle_all(); tx_empty = 0; rx_line = 0; long_frame = 0; rst_n = 0;
    repeat (3) step();
    check("R1 in reset", outs(), 5'b00000);
    rst_n = 1;
    repeat (4) step();
    tx_empty = 1;
    check("R1 after reset", outs(), 5'b00000);
    tx_empty = 0;

    for (int i = 0; i < NV; i++) begin
      ctrl_wr = VEC[i][18]; ctrl_wdata = 16'(VEC[i][17:14]) << 10;
      rx_load = VEC[i][13]; rx_par_err = VEC[i][12]; rx_frm_err = VEC[i][11];
      rx_ovr_err = VEC[i][10]; rx_data_rd = VEC[i][9]; stat_rd = VEC[i][8];
      tx_empty = VEC[i][7]; tmr_uflow = VEC[i][6]; ack_tmr = VEC[i][5];
      step();
      check($sformatf("vector %0d", i), outs(), VEC[i][4:0]);
      idle_all();
    end

    // R2 bits outside 13:10 have no effect
    tx_empty = 1;
    ctrl_wr = 1; ctrl_wdata = 16'hC3FF; step(); idle_all();
    check("R2 other bits ignored", outs(), 5'b00000);
    tx_empty = 0;

    // R8 short frame: 10 high samples
    write_en(4'b0001);
    tick(0, 0);
    for (int k = 0; k < 9; k++) tick(1, 0);
    check("R8 nine highs short", outs(), 5'b00000);
    tick(1, 0);
    check("R8 tenth high fires", outs(), 5'b00010);
    ack_idle = 1; step(); idle_all();
    check("R10 ack clears idle", outs(), 5'b00000);
    for (int k = 0; k < 12; k++) tick(1, 0);
    check("R9 no refire without low", outs(), 5'b00000);

    // R8 long frame: 11 high samples
    long_frame = 1;
    tick(0, 0);
    for (int k = 0; k < 10; k++) tick(1, 0);
    check("R8 ten highs long", outs(), 5'b00000);
    tick(1, 0);
    check("R8 eleventh high fires", outs(), 5'b00010);
    ack_idle = 1; step(); idle_all();

    // R9 low sample restarts the count
    tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    for (int k = 0; k < 10; k++) tick(1, 0);
    check("R9 restart after low", outs(), 5'b00000);
    tick(1, 0);
    check("R9 fires after full run", outs(), 5'b00010);
    ack_idle = 1; step(); idle_all();

    // R10 detection in the acknowledge cycle wins
    long_frame = 0;
    tick(0, 0);
    for (int k = 0; k < 9; k++) tick(1, 0);
    tick(1, 1);
    check("R10 fire beats ack", outs(), 5'b00010);
    ack_idle = 1; step(); idle_all();
    check("R10 ack after collision", outs(), 5'b00000);

    // R11 idle flag latches while disabled
    write_en(4'b0000);
    tick(0, 0);
    for (int k = 0; k < 10; k++) tick(1, 0);
    check("R11 idle masked", outs(), 5'b00000);
    write_en(4'b0001);
    check("R11 idle shown on enable", outs(), 5'b00010);

    // R1 reset mid-run clears flags and enables
    write_en(4'b1111);
    tmr_uflow = 1; rx_load = 1; rx_par_err = 1; step(); idle_all();
    check("R1 pre-reset state", outs(), 5'b01011);
    rst_n = 0; step();
    check("R1 reset mid-run", outs(), 5'b00000);
    rst_n = 1; repeat (3) step();
    write_en(4'b1111);
    check("R1 flags cleared by reset", outs(), 5'b00000);

    finish_run();
  end
endmodule